// File: doc/BRIEF.md
# Pipeline Operand Forwarding Selector

This block chooses where each source operand of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) gets its value. For each of the two source registers of the instruction in execute, it compares the register number against the destinations of the two older instructions still in flight. It then produces a mux select code that picks one of three values: the register-file read, the ALU result held in the execute/memory pipeline register, or the value held in the memory/writeback pipeline register. Because of these selects, a chain of dependent instructions issued back to back runs without stalling.

Branch equality is resolved in decode, so the block produces a second pair of select codes for the two decode-stage comparator operands. The register file writes in the first half of the cycle and reads in the second half. A result in writeback is therefore already visible to decode, and by default decode only forwards from the execute/memory register. A parameter adds a writeback path to decode for register files without that write-first behaviour. The block is purely combinational. Stall generation, the register file and the ALU are outside it.

Top module: `fwd_unit`

## Requirements
- R1: An execute operand whose register matches no enabled, nonzero destination in the memory or writeback stage gets select 2'b00 (register file).
- R2: An execute operand whose register equals the memory-stage destination, with the memory-stage write enable high, gets select 2'b10 (execute/memory register).
- R3: An execute operand that matches only the writeback-stage destination, with the writeback write enable high, gets select 2'b01 (memory/writeback register).
- R4: When both the memory and writeback stages match an execute operand, the memory stage wins and the select is 2'b10.
- R5: A stage whose write enable is low is never forwarded from. Its match then falls to the other stage, or to 2'b00.
- R6: Register 0 is never forwarded. A zero source or a zero destination yields select 2'b00 for that path.
- R7: A decode comparator operand that equals an enabled, nonzero memory-stage destination gets select 2'b10.
- R8: A decode comparator operand that matches only the writeback stage gets 2'b00 when DEC_WB_BYPASS is 0, and 2'b01 when DEC_WB_BYPASS is 1.
- R9: The two operands of each stage are selected independently, and the code 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | AW | First source register of the instruction in execute |
| ex_src_b | input | AW | Second source register of the instruction in execute |
| id_src_a | input | AW | First branch-compare source register in decode |
| id_src_b | input | AW | Second branch-compare source register in decode |
| mem_dst | input | AW | Destination register of the instruction in memory |
| mem_wen | input | 1 | Instruction in memory writes its destination |
| wb_dst | input | AW | Destination register of the instruction in writeback |
| wb_wen | input | 1 | Instruction in writeback writes its destination |
| ex_sel_a | output | 2 | Mux select for execute operand A |
| ex_sel_b | output | 2 | Mux select for execute operand B |
| id_sel_a | output | 2 | Mux select for decode comparator operand A |
| id_sel_b | output | 2 | Mux select for decode comparator operand B |

## Verification
The bench builds two copies of the block on the same inputs, both with AW=5. One copy has DEC_WB_BYPASS=0, the other DEC_WB_BYPASS=1. This puts both decode variants of R8 side by side on a single stimulus, while the execute selects must agree between the copies. With 5-bit register numbers, register 31 and register 0 can both be reached, which covers the top-end compare and the zero-register suppression. A back-to-back dependent chain and an increment-then-branch sequence are replayed cycle by cycle to cover the stage-to-stage timing.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Operand mux select codes, decoded by the datapath muxes
  typedef enum logic [1:0] {
    SEL_RF   = 2'b00,  // register-file read
    SEL_MEMWB = 2'b01, // memory/writeback pipeline register
    SEL_EXMEM = 2'b10  // execute/memory pipeline register (ALU result)
  } sel_t;

  localparam int NUM_EX_OPS  = 2;
  localparam int NUM_ID_OPS  = 2;
  localparam int NUM_OPS     = NUM_EX_OPS + NUM_ID_OPS;

endpackage

// File: rtl/fwd_stage_hit.sv
module fwd_stage_hit #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          wen,
  output logic          hit
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic dst_live;

  // A zero destination counts as no write
  assign dst_live = wen && (dst != ZERO_REG);
  assign hit      = dst_live && (dst == src);

endmodule

// File: rtl/fwd_prio_sel.sv
module fwd_prio_sel #(
  parameter bit USE_FAR = 1'b1
) (
  input  logic          near_hit,
  input  logic          far_hit,
  output fwd_pkg::sel_t sel
);

  import fwd_pkg::*;

  logic far_ok;

  generate
    if (USE_FAR) begin : g_far
      assign far_ok = far_hit;
    end else begin : g_no_far
      logic unused_far;
      assign unused_far = far_hit;
      assign far_ok     = 1'b0;
    end
  endgenerate

  // The nearer (younger) producer wins over the farther one
  always_comb begin
    if (near_hit)    sel = SEL_EXMEM;
    else if (far_ok) sel = SEL_MEMWB;
    else             sel = SEL_RF;
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int AW            = 5,
  parameter bit DEC_WB_BYPASS = 1'b0
) (
  input  logic [AW-1:0] ex_src_a,
  input  logic [AW-1:0] ex_src_b,
  input  logic [AW-1:0] id_src_a,
  input  logic [AW-1:0] id_src_b,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wen,
  output logic [1:0]    ex_sel_a,
  output logic [1:0]    ex_sel_b,
  output logic [1:0]    id_sel_a,
  output logic [1:0]    id_sel_b
);

  import fwd_pkg::*;

  logic [AW-1:0] src_vec [NUM_OPS];
  logic          mem_hit [NUM_OPS];
  logic          wb_hit  [NUM_OPS];
  sel_t          sel_vec [NUM_OPS];

  // Operand slots: execute ops first, then decode comparator ops
  assign src_vec[0] = ex_src_a;
  assign src_vec[1] = ex_src_b;
  assign src_vec[2] = id_src_a;
  assign src_vec[3] = id_src_b;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_OPS; gi++) begin : g_op
      localparam bit IS_EX   = (gi < NUM_EX_OPS);
      localparam bit FAR_ON  = IS_EX ? 1'b1 : DEC_WB_BYPASS;

      fwd_stage_hit #(.AW(AW)) u_mem_hit (
        .src (src_vec[gi]),
        .dst (mem_dst),
        .wen (mem_wen),
        .hit (mem_hit[gi])
      );

      fwd_stage_hit #(.AW(AW)) u_wb_hit (
        .src (src_vec[gi]),
        .dst (wb_dst),
        .wen (wb_wen),
        .hit (wb_hit[gi])
      );

      fwd_prio_sel #(.USE_FAR(FAR_ON)) u_sel (
        .near_hit (mem_hit[gi]),
        .far_hit  (wb_hit[gi]),
        .sel      (sel_vec[gi])
      );
    end
  endgenerate

  assign ex_sel_a = sel_vec[0];
  assign ex_sel_b = sel_vec[1];
  assign id_sel_a = sel_vec[2];
  assign id_sel_b = sel_vec[3];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int AW            = 5,
  parameter bit DEC_WB_BYPASS = 1'b0
) (
  input logic [AW-1:0] ex_src_a,
  input logic [AW-1:0] ex_src_b,
  input logic [AW-1:0] id_src_a,
  input logic [AW-1:0] id_src_b,
  input logic [AW-1:0] mem_dst,
  input logic          mem_wen,
  input logic [AW-1:0] wb_dst,
  input logic          wb_wen,
  input logic [1:0]    ex_sel_a,
  input logic [1:0]    ex_sel_b,
  input logic [1:0]    id_sel_a,
  input logic [1:0]    id_sel_b
);

  always_comb begin
    // R6
    if (ex_src_a == '0)
      ex_zero_src_chk: assert (ex_sel_a == 2'b00) else $error("ex_zero_src_chk");
    // R4
    if (mem_wen && mem_dst != '0 && mem_dst == ex_src_b)
      ex_mem_prio_chk: assert (ex_sel_b == 2'b10) else $error("ex_mem_prio_chk");
    // R5
    if (!mem_wen && !wb_wen)
      no_write_chk: assert (ex_sel_a == 2'b00 && ex_sel_b == 2'b00 &&
                            id_sel_a == 2'b00 && id_sel_b == 2'b00)
        else $error("no_write_chk");
    // R8
    if (!DEC_WB_BYPASS)
      id_no_wb_chk: assert (id_sel_a != 2'b01 && id_sel_b != 2'b01) else $error("id_no_wb_chk");
    // R9
    no_bad_code_chk: assert (ex_sel_a != 2'b11 && ex_sel_b != 2'b11 &&
                             id_sel_a != 2'b11 && id_sel_b != 2'b11)
      else $error("no_bad_code_chk");
    // R7
    if (mem_wen && mem_dst != '0 && mem_dst == id_src_a)
      id_mem_fwd_chk: assert (id_sel_a == 2'b10) else $error("id_mem_fwd_chk");
  end

endmodule

bind fwd_unit fwd_unit_chk #(.AW(AW), .DEC_WB_BYPASS(DEC_WB_BYPASS)) u_chk (
  .ex_src_a (ex_src_a),
  .ex_src_b (ex_src_b),
  .id_src_a (id_src_a),
  .id_src_b (id_src_b),
  .mem_dst  (mem_dst),
  .mem_wen  (mem_wen),
  .wb_dst   (wb_dst),
  .wb_wen   (wb_wen),
  .ex_sel_a (ex_sel_a),
  .ex_sel_b (ex_sel_b),
  .id_sel_a (id_sel_a),
  .id_sel_b (id_sel_b)
);

// File: tb/test_fwd_unit.sv
`timescale 1ns/1ps
module test_fwd_unit;

  localparam int AW = 5;
  localparam int NV = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [AW-1:0] ex_src_a, ex_src_b, id_src_a, id_src_b, mem_dst, wb_dst;
  logic          mem_wen, wb_wen;
  logic [1:0]    ex_sel_a, ex_sel_b, id_sel_a, id_sel_b;
  logic [1:0]    w_ex_sel_a, w_ex_sel_b, w_id_sel_a, w_id_sel_b;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  fwd_unit #(.AW(AW), .DEC_WB_BYPASS(1'b0)) i_fwd_unit (
    .ex_src_a, .ex_src_b, .id_src_a, .id_src_b,
    .mem_dst, .mem_wen, .wb_dst, .wb_wen,
    .ex_sel_a, .ex_sel_b, .id_sel_a, .id_sel_b
  );

  fwd_unit #(.AW(AW), .DEC_WB_BYPASS(1'b1)) i_fwd_unit_wbb (
    .ex_src_a, .ex_src_b, .id_src_a, .id_src_b,
    .mem_dst, .mem_wen, .wb_dst, .wb_wen,
    .ex_sel_a(w_ex_sel_a), .ex_sel_b(w_ex_sel_b),
    .id_sel_a(w_id_sel_a), .id_sel_b(w_id_sel_b)
  );

  // {ex_src_a, ex_src_b, mem_dst, mem_wen, wb_dst, wb_wen, exp_a, exp_b}
  localparam logic [25:0] VEC [NV] = '{
    {5'd1,  5'd2,  5'd0,  1'b0, 5'd0,  1'b0, 2'b00, 2'b00}, // R1 nothing in flight
    {5'd8,  5'd9,  5'd8,  1'b1, 5'd3,  1'b1, 2'b10, 2'b00}, // R2
    {5'd8,  5'd9,  5'd5,  1'b1, 5'd9,  1'b1, 2'b00, 2'b01}, // R3
    {5'd8,  5'd8,  5'd8,  1'b1, 5'd8,  1'b1, 2'b10, 2'b10}, // R4
    {5'd8,  5'd9,  5'd8,  1'b0, 5'd9,  1'b0, 2'b00, 2'b00}, // R5 both off
    {5'd8,  5'd9,  5'd8,  1'b0, 5'd8,  1'b1, 2'b01, 2'b00}, // R5 mem off falls to wb
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R6
    {5'd31, 5'd31, 5'd31, 1'b1, 5'd0,  1'b1, 2'b10, 2'b10}, // R2 top register
    {5'd4,  5'd7,  5'd7,  1'b1, 5'd4,  1'b1, 2'b01, 2'b10}, // R9 independent
    {5'd3,  5'd6,  5'd2,  1'b1, 5'd5,  1'b1, 2'b00, 2'b00}  // R1 no match
  };

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [AW-1:0] ea, eb, ia, ib, md, input logic mw,
                       input logic [AW-1:0] wd, input logic ww);
    @(negedge clk);
    ex_src_a = ea; ex_src_b = eb; id_src_a = ia; id_src_b = ib;
    mem_dst = md; mem_wen = mw; wb_dst = wd; wb_wen = ww;
    #1;
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 idle state: all zero inputs
    drive('0, '0, '0, '0, '0, 1'b0, '0, 1'b0);
    chk("R1 idle ex_a", ex_sel_a, 2'b00);
    chk("R1 idle id_a", id_sel_a, 2'b00);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][25:21], VEC[i][20:16], '0, '0, VEC[i][15:11], VEC[i][10],
            VEC[i][9:5], VEC[i][4]);
      chk($sformatf("R2/R3/R4 table row %0d ex_a", i), ex_sel_a, VEC[i][3:2]);
      chk($sformatf("R9 table row %0d ex_b", i), ex_sel_b, VEC[i][1:0]);
      chk($sformatf("R9 table row %0d bypass copy ex_a", i), w_ex_sel_a, VEC[i][3:2]);
    end

    // R2/R3 dependent chain on register 8: producer in memory, then in writeback
    drive(5'd8, 5'd11, '0, '0, 5'd8, 1'b1, 5'd0, 1'b0);
    chk("R2 chain second instr", ex_sel_a, 2'b10);
    drive(5'd12, 5'd8, '0, '0, 5'd4, 1'b1, 5'd8, 1'b1);
    chk("R3 chain third instr", ex_sel_b, 2'b01);
    drive(5'd8, 5'd13, '0, '0, 5'd5, 1'b1, 5'd12, 1'b1);
    chk("R1 chain fourth instr from regfile", ex_sel_a, 2'b00);

    // R7 increment of register 17 in memory, branch in decode compares 17 with 18
    drive('0, '0, 5'd17, 5'd18, 5'd17, 1'b1, 5'd0, 1'b0);
    chk("R7 branch a", id_sel_a, 2'b10);
    chk("R7 branch b", id_sel_b, 2'b00);
    drive('0, '0, 5'd18, 5'd17, 5'd17, 1'b1, 5'd18, 1'b1);
    chk("R7 branch b from mem", id_sel_b, 2'b10);
    chk("R8 branch a wb only, no bypass", id_sel_a, 2'b00);
    chk("R8 branch a wb only, bypass", w_id_sel_a, 2'b01);

    // R8 both stages match decode: memory still wins in both variants
    drive('0, '0, 5'd6, 5'd6, 5'd6, 1'b1, 5'd6, 1'b1);
    chk("R8 decode prio no bypass", id_sel_a, 2'b10);
    chk("R8 decode prio bypass", w_id_sel_b, 2'b10);

    // R6 zero register on the decode side
    drive('0, '0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
    chk("R6 decode zero a", w_id_sel_a, 2'b00);
    chk("R6 decode zero b", id_sel_b, 2'b00);

    // R5 disabled memory stage on decode side
    drive('0, '0, 5'd9, 5'd2, 5'd9, 1'b0, 5'd9, 1'b0);
    chk("R5 decode mem off", id_sel_a, 2'b00);
    chk("R5 decode mem off bypass", w_id_sel_a, 2'b00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule